// File: doc/BRIEF.md
# DMA Interface Register File

This block is the host-visible register set of a 16-bit parallel DMA port. A host issues word reads and writes to a window of four word addresses starting at a configurable base. Behind that window sit a transfer word count, a transfer bus address, a control/status word and a data buffer. The block also drives a small set of lines to an attached user device and samples lines coming back from it. Additional instances are placed at bases spaced 040 octal apart. The bus sequencing that performs the actual transfers lives elsewhere. This block only holds and updates the register state that the sequencer and the device see.

The control/status address is shared by two views. Host writes there always land in the control word. A view-select flag, written through bit 15, decides whether a read returns the control word or a read-only error/information word. The data buffer address is also split. A write loads an output latch that drives the device. A read returns a separate input latch, which captures device data when that address is read and whenever the device raises either cycle-request line.

Top module: `dma_regfile`

## Requirements
- R1: On reset (rst_ni low), the count, address, control fields, view-select flag and both data latches are cleared to zero. dev_ready_o is 1 and dev_go_o is 0.
- R2: A host access is decoded only when the address lies in BASE..BASE+7 and bit 0 of the address is 0. Offset bits [2:1] select the register: 0 is word count, 1 is bus address, 2 is control/status, 3 is data buffer. Writes to any other address change nothing. Reads of any other address, and host_rdata_o while no read is strobed, return 0.
- R3: A write to word count or bus address stores data bits 15..1. A read of either returns the stored bits 15..1, with dev_bit0_i in bit 0.
- R4: With the view select at 0, a control/status read returns these bits: 15 ERROR, 14 NXM, 13 the live attention input, 12 MAINT, 11..9 the live dev_stat_i, 8 CYCLE, 7 READY, 6 IE, 5..4 extended address, 3..1 FUNC, 0 view select.
- R5: With the view select at 1, a control/status read returns the error/information word. Bit 15 is ERROR, bit 14 is NXM and bit 13 is the live attention input. Bits 12..8 are error sources with no driver in this block and read 0. Bits 7..1 read 0, and bit 0 reads the view select.
- R6: A control/status write updates the control word whatever the view select holds. Written bit 15 becomes the view select. Bits 14, 12, 6, 5..4 and 3..1 are stored as NXM, MAINT, IE, extended address and FUNC.
- R7: A control/status write with bit 0 set raises dev_go_o for exactly the next clock and clears READY at the same edge. When no such write is made, READY returns to 1 on the first edge at which dev_attn_i is high.
- R8: ERROR becomes 1 on the edge after a clock in which NXM or dev_attn_i is 1, and it stays set. A control/status write with bit 15 at 0 clears it, and this takes priority over setting it.
- R9: A data buffer write loads the output latch, and dev_data_o drives the latch value from the following clock.
- R10: A data buffer read returns the input latch as it stands. At that edge, and at every edge where either cyc_req_i bit is 1, the latch loads dev_data_i.
- R11: CYCLE (control bit 8, shown on cycle_o) is set by either cyc_req_i bit and can also be written by the host. A request beats a host write of 0 in the same clock.
- R12: dev_func_o always shows the stored FUNC field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low bus reset |
| host_rd_i | input | 1 | Host read strobe; data is returned combinationally in the same clock |
| host_wr_i | input | 1 | Host write strobe, taken at the clock edge |
| host_addr_i | input | AW (18) | Host byte address |
| host_wdata_i | input | DW (16) | Host write data |
| host_rdata_o | output | DW (16) | Host read data |
| dev_data_i | input | DW (16) | Data from the user device |
| dev_stat_i | input | 3 | Device status lines, shown in control bits 11..9 |
| dev_attn_i | input | 1 | Device attention line |
| dev_bit0_i | input | 1 | Bit 0 of word count and bus address, supplied by the device |
| cyc_req_i | input | 2 | Device cycle-request lines |
| dev_data_o | output | DW (16) | Output latch to the user device |
| dev_func_o | output | 3 | FUNC field to the user device |
| dev_go_o | output | 1 | One-clock start pulse |
| dev_ready_o | output | 1 | READY flag |
| cycle_o | output | 1 | Cycle-request flag for the bus sequencer |

## Verification
The assertions take it for granted that the host never strobes a read and a write in the same clock. They also assume every input is a known value at each edge. Under those conditions a write's effects appear exactly one edge later, and a read sees only state that is already registered. The random stimulus chooses one operation per clock, either idle, read or write, so the two strobes never overlap. It drives every device input with a defined value at each step. Attention and the cycle requests are raised only occasionally, so that READY, ERROR and CYCLE are seen both being set and being cleared.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  // register slot selected by address bits [2:1]
  localparam int NREG    = 4;
  localparam int OFF_WC  = 0;
  localparam int OFF_BA  = 1;
  localparam int OFF_CSR = 2;
  localparam int OFF_DB  = 3;
  localparam int NCNT    = 2;  // word count and bus address share one layout
  localparam int CSR_W   = 16;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
#(
  parameter int              AW   = 18,
  parameter logic [AW-1:0]   BASE = 18'o772410
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  output logic            hit_o,
  output logic [NREG-1:0] rd_sel_o,
  output logic [NREG-1:0] wr_sel_o
);
  logic [1:0] slot;

  assign hit_o = (addr_i[AW-1:3] == BASE[AW-1:3]) && !addr_i[0];
  assign slot  = addr_i[2:1];

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign rd_sel_o[k] = rd_i && hit_o && (slot == 2'(k));
    assign wr_sel_o[k] = wr_i && hit_o && (slot == 2'(k));
  end

  assert_sel_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_sel_o) |-> (addr_i >= BASE) && (addr_i < BASE + AW'(8)) && !addr_i[0]);
endmodule

// File: rtl/dma_rf_word.sv
module dma_rf_word #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:1] wdata_i,
  input  logic          bit0_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:1] word_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   word_q <= '0;
    else if (wr_i) word_q <= wdata_i;

  assign rdata_o = {word_q, bit0_i};

  assert_word_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i) |-> word_q == $past(wdata_i));
endmodule

// File: rtl/dma_rf_ctl.sv
module dma_rf_ctl
  import dma_rf_pkg::*;
#(
  parameter int NCYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic [2:0]       stat_i,
  input  logic             attn_i,
  input  logic [NCYC-1:0]  cyc_req_i,
  output logic [CSR_W-1:0] csr_o,
  output logic [CSR_W-1:0] eir_o,
  output logic             regsel_o,
  output logic [2:0]       func_o,
  output logic             go_o,
  output logic             ready_o,
  output logic             cycle_o
);
  logic       err_q, nxm_q, maint_q, cycle_q, ready_q, ie_q, regsel_q, go_q;
  logic [1:0] xba_q;
  logic [2:0] func_q;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata_i[13], wdata_i[11:9], wdata_i[7]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0; nxm_q <= 1'b0; maint_q <= 1'b0; cycle_q <= 1'b0;
      ie_q <= 1'b0; regsel_q <= 1'b0; go_q <= 1'b0;
      xba_q <= '0; func_q <= '0;
      ready_q <= 1'b1;
    end else begin
      go_q <= wr_i && wdata_i[0];
      if (wr_i) begin
        regsel_q <= wdata_i[15];
        nxm_q    <= wdata_i[14];
        maint_q  <= wdata_i[12];
        ie_q     <= wdata_i[6];
        xba_q    <= wdata_i[5:4];
        func_q   <= wdata_i[3:1];
      end
      // a device request beats a host clear
      if (|cyc_req_i) cycle_q <= 1'b1;
      else if (wr_i)  cycle_q <= wdata_i[8];
      if (wr_i && wdata_i[0]) ready_q <= 1'b0;
      else if (attn_i)        ready_q <= 1'b1;
      if (wr_i && !wdata_i[15])    err_q <= 1'b0;
      else if (nxm_q || attn_i)    err_q <= 1'b1;
    end
  end

  assign csr_o = {err_q, nxm_q, attn_i, maint_q, stat_i, cycle_q, ready_q,
                  ie_q, xba_q, func_q, regsel_q};
  assign eir_o = {err_q, nxm_q, attn_i, 5'b0, 7'b0, regsel_q};
  assign regsel_o = regsel_q;
  assign func_o   = func_q;
  assign go_o     = go_q;
  assign ready_o  = ready_q;
  assign cycle_o  = cycle_q;

  assert_regsel_written_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i) |-> regsel_q == $past(wdata_i[15]));
  assert_go_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(wr_i && wdata_i[0]));
  assert_go_drops_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> !ready_o);
  assert_err_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && !wdata_i[15]) |-> !err_q);
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_q && !(wr_i && !wdata_i[15])) |-> err_q);
  assert_cycle_req_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(|cyc_req_i) |-> cycle_o);
endmodule

// File: rtl/dma_rf_dbuf.sv
module dma_rf_dbuf #(
  parameter int DW   = 16,
  parameter int NCYC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [NCYC-1:0] cyc_req_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   dev_data_i,
  output logic [DW-1:0]   out_o,
  output logic [DW-1:0]   in_o
);
  logic [DW-1:0] out_q, in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      if (wr_i) out_q <= wdata_i;
      if (rd_i || (|cyc_req_i)) in_q <= dev_data_i;
    end
  end

  assign out_o = out_q;
  assign in_o  = in_q;

  assert_out_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i) |-> out_o == $past(wdata_i));
  assert_in_sample_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i || (|cyc_req_i)) |-> in_o == $past(dev_data_i));
  assert_in_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rd_i && !(|cyc_req_i)) |-> $stable(in_o));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int            DW   = 16,
  parameter int            AW   = 18,
  parameter int            NCYC = 2,
  parameter logic [AW-1:0] BASE = 18'o772410
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            host_rd_i,
  input  logic            host_wr_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [DW-1:0]   host_wdata_i,
  output logic [DW-1:0]   host_rdata_o,
  input  logic [DW-1:0]   dev_data_i,
  input  logic [2:0]      dev_stat_i,
  input  logic            dev_attn_i,
  input  logic            dev_bit0_i,
  input  logic [NCYC-1:0] cyc_req_i,
  output logic [DW-1:0]   dev_data_o,
  output logic [2:0]      dev_func_o,
  output logic            dev_go_o,
  output logic            dev_ready_o,
  output logic            cycle_o
);
  logic [NREG-1:0]  rd_sel, wr_sel;
  logic             hit, regsel;
  logic [DW-1:0]    cnt_rd [NCNT];
  logic [CSR_W-1:0] csr_w, eir_w;
  logic [DW-1:0]    in_latch;

  dma_rf_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .clk_i, .rst_ni, .rd_i(host_rd_i), .wr_i(host_wr_i), .addr_i(host_addr_i),
    .hit_o(hit), .rd_sel_o(rd_sel), .wr_sel_o(wr_sel)
  );

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    dma_rf_word #(.DW(DW)) u_word (
      .clk_i, .rst_ni, .wr_i(wr_sel[k]), .wdata_i(host_wdata_i[DW-1:1]),
      .bit0_i(dev_bit0_i), .rdata_o(cnt_rd[k])
    );
  end

  dma_rf_ctl #(.NCYC(NCYC)) u_ctl (
    .clk_i, .rst_ni, .wr_i(wr_sel[OFF_CSR]), .wdata_i(host_wdata_i[CSR_W-1:0]),
    .stat_i(dev_stat_i), .attn_i(dev_attn_i), .cyc_req_i,
    .csr_o(csr_w), .eir_o(eir_w), .regsel_o(regsel), .func_o(dev_func_o),
    .go_o(dev_go_o), .ready_o(dev_ready_o), .cycle_o
  );

  dma_rf_dbuf #(.DW(DW), .NCYC(NCYC)) u_dbuf (
    .clk_i, .rst_ni, .wr_i(wr_sel[OFF_DB]), .rd_i(rd_sel[OFF_DB]), .cyc_req_i,
    .wdata_i(host_wdata_i), .dev_data_i, .out_o(dev_data_o), .in_o(in_latch)
  );

  always_comb begin
    host_rdata_o = '0;
    if (rd_sel[OFF_WC])       host_rdata_o = cnt_rd[OFF_WC];
    else if (rd_sel[OFF_BA])  host_rdata_o = cnt_rd[OFF_BA];
    else if (rd_sel[OFF_CSR]) host_rdata_o = DW'(regsel ? eir_w : csr_w);
    else if (rd_sel[OFF_DB])  host_rdata_o = in_latch;
  end

  assert_miss_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_rd_i || !hit) |-> host_rdata_o == '0);
  assert_eir_low_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel[OFF_CSR] && regsel) |-> host_rdata_o[12:1] == '0);
endmodule

// File: tb/tb_dma_regfile.sv
`timescale 1ns/1ps
module tb_dma_regfile;
  localparam int            DW   = 16;
  localparam int            AW   = 18;
  localparam logic [AW-1:0] BASE = 18'o772410;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic host_rd_i = 0, host_wr_i = 0;
  logic [AW-1:0] host_addr_i = '0;
  logic [DW-1:0] host_wdata_i = '0, host_rdata_o;
  logic [DW-1:0] dev_data_i = '0, dev_data_o;
  logic [2:0] dev_stat_i = '0, dev_func_o;
  logic dev_attn_i = 0, dev_bit0_i = 0, dev_go_o, dev_ready_o, cycle_o;
  logic [1:0] cyc_req_i = '0;

  dma_regfile #(.DW(DW), .AW(AW), .NCYC(2), .BASE(BASE)) dut (.*);

  always #2 clk_i = ~clk_i;

  int errs = 0, checks = 0;
  bit done = 0;

  // reference state
  logic [15:1] m_wc, m_ba;
  logic m_err, m_nxm, m_maint, m_cycle, m_ready, m_ie, m_regsel, m_go;
  logic [1:0] m_xba;
  logic [2:0] m_func;
  logic [15:0] m_in, m_out;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic hit_of(logic [AW-1:0] a);
    return (a[AW-1:3] == BASE[AW-1:3]) && !a[0];
  endfunction

  function automatic logic [15:0] exp_csr();
    return {m_err, m_nxm, dev_attn_i, m_maint, dev_stat_i, m_cycle, m_ready,
            m_ie, m_xba, m_func, m_regsel};
  endfunction

  function automatic logic [15:0] exp_eir();
    return {m_err, m_nxm, dev_attn_i, 12'h000, m_regsel};
  endfunction

  function automatic logic [15:0] exp_rd();
    if (!host_rd_i || !hit_of(host_addr_i)) return 16'h0;
    case (host_addr_i[2:1])
      2'd0: return {m_wc, dev_bit0_i};
      2'd1: return {m_ba, dev_bit0_i};
      2'd2: return m_regsel ? exp_eir() : exp_csr();
      default: return m_in;
    endcase
  endfunction

  function automatic string rd_tag();
    if (!host_rd_i || !hit_of(host_addr_i)) return "R2";
    case (host_addr_i[2:1])
      2'd0, 2'd1: return "R3";
      2'd2: return m_regsel ? "R5" : "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic model_reset();
    m_wc = '0; m_ba = '0; m_err = 0; m_nxm = 0; m_maint = 0; m_cycle = 0;
    m_ready = 1; m_ie = 0; m_regsel = 0; m_go = 0; m_xba = '0; m_func = '0;
    m_in = '0; m_out = '0;
  endtask

  // one clock with model update, then output checks
  task automatic step();
    logic h, wcsr;
    logic [1:0] ix;
    logic [15:0] wd;
    logic [15:1] n_wc, n_ba;
    logic n_err, n_nxm, n_maint, n_cycle, n_ready, n_ie, n_regsel, n_go;
    logic [1:0] n_xba;
    logic [2:0] n_func;
    logic [15:0] n_in, n_out;
    h = hit_of(host_addr_i); ix = host_addr_i[2:1]; wd = host_wdata_i;
    wcsr = host_wr_i && h && ix == 2'd2;
    n_wc = (host_wr_i && h && ix == 2'd0) ? wd[15:1] : m_wc;
    n_ba = (host_wr_i && h && ix == 2'd1) ? wd[15:1] : m_ba;
    n_out = (host_wr_i && h && ix == 2'd3) ? wd : m_out;
    n_in = ((host_rd_i && h && ix == 2'd3) || (|cyc_req_i)) ? dev_data_i : m_in;
    n_regsel = wcsr ? wd[15] : m_regsel;
    n_nxm = wcsr ? wd[14] : m_nxm;
    n_maint = wcsr ? wd[12] : m_maint;
    n_ie = wcsr ? wd[6] : m_ie;
    n_xba = wcsr ? wd[5:4] : m_xba;
    n_func = wcsr ? wd[3:1] : m_func;
    n_go = wcsr && wd[0];
    n_cycle = (|cyc_req_i) ? 1'b1 : (wcsr ? wd[8] : m_cycle);
    n_ready = (wcsr && wd[0]) ? 1'b0 : (dev_attn_i ? 1'b1 : m_ready);
    n_err = (wcsr && !wd[15]) ? 1'b0 : (m_err | m_nxm | dev_attn_i);
    @(posedge clk_i); #1;
    m_wc = n_wc; m_ba = n_ba; m_out = n_out; m_in = n_in; m_regsel = n_regsel;
    m_nxm = n_nxm; m_maint = n_maint; m_ie = n_ie; m_xba = n_xba; m_func = n_func;
    m_go = n_go; m_cycle = n_cycle; m_ready = n_ready; m_err = n_err;
    chk("R9 dev_data_o", dev_data_o, m_out);
    chk("R12 dev_func_o", dev_func_o, m_func);
    chk("R7 dev_go_o", dev_go_o, m_go);
    chk("R7 dev_ready_o", dev_ready_o, m_ready);
    chk("R11 cycle_o", cycle_o, m_cycle);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    host_wr_i = 1; host_rd_i = 0; host_addr_i = a; host_wdata_i = d;
    step();
    host_wr_i = 0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    host_rd_i = 1; host_wr_i = 0; host_addr_i = a;
    #1 chk(rd_tag(), host_rdata_o, exp_rd());
    step();
    host_rd_i = 0;
  endtask

  task automatic idle();
    host_rd_i = 0; host_wr_i = 0;
    #1 chk("R2 idle rdata", host_rdata_o, 16'h0);
    step();
  endtask

  initial begin
    model_reset();
    #5;
    chk("R1 reset ready", dev_ready_o, 1'b1);
    chk("R1 reset go", dev_go_o, 1'b0);
    chk("R1 reset data_o", dev_data_o, 16'h0);
    #2 rst_ni = 1'b1;  // released at 7 ns, one unit after an edge
    rd(BASE + 0); rd(BASE + 2); rd(BASE + 4); rd(BASE + 6);
    // R3: bit 0 from device
    wr(BASE + 0, 16'hFFFF); rd(BASE + 0);
    dev_bit0_i = 1; rd(BASE + 0);
    wr(BASE + 2, 16'h1234); rd(BASE + 2);
    dev_bit0_i = 0; rd(BASE + 2);
    // R2: outside window and odd addresses ignored
    wr(BASE + 8, 16'h0F0F); wr(BASE + 1, 16'h0000); wr(BASE - 2, 16'hAAAA);
    rd(BASE + 0); rd(BASE + 8); rd(BASE + 1);
    // R4/R6: control write with view 0
    dev_stat_i = 3'b101;
    wr(BASE + 4, 16'h107E); rd(BASE + 4);
    // R5/R6: switch to info view, writes still reach control word
    wr(BASE + 4, 16'hC00A); rd(BASE + 4);
    wr(BASE + 4, 16'h800C); rd(BASE + 4); idle(); rd(BASE + 4);
    // R8: clear error with bit 15 = 0 and NXM = 0
    wr(BASE + 4, 16'h0000); rd(BASE + 4); idle(); rd(BASE + 4);
    // R7: GO pulse, READY drop and recovery by attention
    wr(BASE + 4, 16'h0001); idle(); idle();
    dev_attn_i = 1; idle(); dev_attn_i = 0; rd(BASE + 4);
    wr(BASE + 4, 16'h0000);
    // R9/R10: data buffer
    wr(BASE + 6, 16'hBEEF);
    dev_data_i = 16'h1357; rd(BASE + 6); rd(BASE + 6);
    dev_data_i = 16'h2468; cyc_req_i = 2'b10; idle(); cyc_req_i = 2'b00;
    dev_data_i = 16'h9999; rd(BASE + 6);
    // R11: request beats a host clear
    cyc_req_i = 2'b01; wr(BASE + 4, 16'h0000); cyc_req_i = 2'b00;
    wr(BASE + 4, 16'h0000); rd(BASE + 4);
    // random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 600; i++) begin
      int op, off;
      dev_data_i = 16'($urandom);
      dev_stat_i = 3'($urandom);
      dev_bit0_i = 1'($urandom);
      dev_attn_i = ($urandom % 8) == 0;
      cyc_req_i  = {($urandom % 8) == 0, ($urandom % 8) == 0};
      op  = $urandom % 3;
      off = $urandom % 12;
      if (op == 0) idle();
      else if (op == 1) wr(BASE + AW'(off), 16'($urandom));
      else rd(BASE + AW'(off));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule